// File: doc/BRIEF.md
# Dead-Time Trimming Neutral-Point Balancer

This block keeps the midpoint of a split dc-link centred by trimming the dead-times of a three-level phase-leg. Once per carrier period, on a sample strobe, it reads the sampled voltages of the upper and lower dc-link capacitors. It forms a signed control error from them and passes it to one of two controllers: a two-position controller with a hysteresis band, or a fixed-point PI controller with an anti-windup integrator. The result is a signed dead-time offset.

The sign of the offset selects which of two dead-time channels receives it. A negative offset lengthens the raising channel (`td_raise`). That channel is the dead-time of the outer-upper/inner-lower switch pair, and a longer value lifts the neutral point. A positive offset lengthens the lowering channel (`td_lower`), the dead-time of the other pair, and a longer value pulls the neutral point down. The offset magnitude is added to a programmable minimum dead-time. Each sum is then clamped to a programmable maximum. The correction needs no knowledge of the direction of power flow.

An enable input holds balancing off. While it is low, both outputs sit at the minimum dead-time and all controller state is cleared. When it is released, correction resumes from the next strobe.

Top module: `npb_deadtime_ctrl`

## Requirements
- R1: While `en` is low, at each clock edge both outputs load `min_dt`, the PI integrator clears to 0 and the two-position held offset clears to 0.
- R2: While `en` is high, the outputs and all controller state change only at clock edges where `sample_stb` is high; otherwise they hold.
- R3: The control error is `ce = v_lower - v_upper`, with both inputs taken as unsigned, in W+1 bit two's complement.
- R4: Two-position rule. If `ce > hyst` the offset is `+step`. If `ce < -hyst` it is `-step`. Otherwise the held offset is kept, and it is 0 after reset or after a disabled period.
- R5: PI rule. With `span = max_dt - min_dt`, the integrator becomes `acc + ki*ce`, clamped to ±(span·2^FRAC). The offset is floor((kp·ce + new acc) / 2^FRAC), clamped to ±span. FRAC defaults to 4.
- R6: `mode_pi` = 1 selects the PI offset and 0 selects the two-position offset. Both controllers update their state at every enabled strobe, whichever mode is selected.
- R7: For a negative offset, `td_raise` = `min_dt + |offset|` and `td_lower` = `min_dt`.
- R8: For a positive offset, `td_lower` = `min_dt + offset` and `td_raise` = `min_dt`. A zero offset gives `min_dt` on both outputs.
- R9: Each output is limited to `max_dt`. Callers keep `max_dt >= min_dt`.
- R10: Synchronous active-high `rst` sets both outputs and all controller state to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Balancing enable |
| sample_stb | input | 1 | One-cycle strobe per carrier period |
| mode_pi | input | 1 | 1 = PI, 0 = two-position |
| v_upper | input | W | Upper capacitor voltage sample (unsigned) |
| v_lower | input | W | Lower capacitor voltage sample (unsigned) |
| hyst | input | W | Two-position hysteresis half-band |
| step | input | DTW | Two-position offset magnitude |
| kp | input | GW | Proportional gain (unsigned, FRAC fractional bits) |
| ki | input | GW | Integral gain per strobe (unsigned, FRAC fractional bits) |
| min_dt | input | DTW | Minimum dead-time in clock ticks |
| max_dt | input | DTW | Dead-time limiter ceiling |
| td_raise | output | DTW | Dead-time of the pair whose lengthening raises the neutral point |
| td_lower | output | DTW | Dead-time of the pair whose lengthening lowers the neutral point |

## Verification
Some properties are checked on every cycle:
- while disabled, both outputs follow the minimum dead-time;
- between strobes, the outputs hold;
- after a strobe, neither output exceeds the ceiling;
- after a strobe, at most one channel sits above the minimum;
- in two-position mode, an error above the band leaves the raising channel at the minimum.

The bench scenarios are needed for the remaining behaviour, because those properties cannot show it:
- the exact offset values;
- the hysteresis hold;
- the integrator clamp;
- the floor rounding of the PI output;
- the way both controllers keep updating across mode changes.

// File: rtl/npb_pkg.sv
package npb_pkg;
  typedef enum logic [1:0] {
    OFS_ZERO = 2'd0,
    OFS_POS  = 2'd1,
    OFS_NEG  = 2'd2
  } ofs_sign_e;

  localparam int unsigned CH_RAISE = 0;
  localparam int unsigned CH_LOWER = 1;
  localparam int unsigned N_CH     = 2;
endpackage

// File: rtl/npb_err.sv
module npb_err #(
  parameter int W = 12
) (
  input  logic [W-1:0]        v_upper,
  input  logic [W-1:0]        v_lower,
  output logic signed [W:0]   ce
);
  always_comb begin
    ce = $signed({1'b0, v_lower}) - $signed({1'b0, v_upper});
  end
endmodule

// File: rtl/npb_bang.sv
module npb_bang #(
  parameter int W   = 12,
  parameter int DTW = 10,
  localparam int OW = DTW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 upd,
  input  logic signed [W:0]    ce,
  input  logic [W-1:0]         hyst,
  input  logic [DTW-1:0]       step,
  output logic signed [OW-1:0] ofs_nxt
);
  logic signed [OW-1:0] held_q;
  logic signed [W+1:0]  ce_x;
  logic signed [W+1:0]  band_hi;
  logic signed [W+1:0]  band_lo;
  logic signed [OW-1:0] step_s;

  always_comb begin
    ce_x    = {ce[W], ce};
    band_hi = $signed({2'b00, hyst});
    band_lo = -band_hi;
    step_s  = $signed({2'b00, step});
    if (ce_x > band_hi)      ofs_nxt = step_s;
    else if (ce_x < band_lo) ofs_nxt = -step_s;
    else                     ofs_nxt = held_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  held_q <= '0;
    else if (upd)    held_q <= ofs_nxt;
  end
endmodule

// File: rtl/npb_pi.sv
module npb_pi #(
  parameter int W    = 12,
  parameter int GW   = 8,
  parameter int DTW  = 10,
  parameter int FRAC = 4,
  localparam int OW  = DTW + 2,
  localparam int PW  = W + GW + 2,
  localparam int AW  = PW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 upd,
  input  logic signed [W:0]    ce,
  input  logic [GW-1:0]        kp,
  input  logic [GW-1:0]        ki,
  input  logic signed [OW-1:0] span,
  output logic signed [OW-1:0] ofs_nxt
);
  logic signed [AW-1:0] acc_q;
  logic signed [AW-1:0] acc_sum;
  logic signed [AW-1:0] acc_nxt;
  logic signed [AW-1:0] lim;
  logic signed [AW-1:0] span_x;
  logic signed [PW-1:0] p_term;
  logic signed [PW-1:0] i_term;
  logic signed [AW-1:0] pre;
  logic signed [AW-1:0] u_raw;

  always_comb begin
    p_term  = $signed({1'b0, kp}) * ce;
    i_term  = $signed({1'b0, ki}) * ce;
    span_x  = AW'(span);
    lim     = span_x <<< FRAC;
    acc_sum = acc_q + AW'(i_term);
    if (acc_sum > lim)        acc_nxt = lim;
    else if (acc_sum < -lim)  acc_nxt = -lim;
    else                      acc_nxt = acc_sum;
    pre   = AW'(p_term) + acc_nxt;
    u_raw = pre >>> FRAC;
    if (u_raw > span_x)       ofs_nxt = span;
    else if (u_raw < -span_x) ofs_nxt = -span;
    else                      ofs_nxt = OW'(u_raw);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  acc_q <= '0;
    else if (upd)    acc_q <= acc_nxt;
  end
endmodule

// File: rtl/npb_limit.sv
module npb_limit
  import npb_pkg::*;
#(
  parameter int DTW = 10,
  localparam int OW = DTW + 2
) (
  input  logic signed [OW-1:0] ofs,
  input  logic [DTW-1:0]       min_dt,
  input  logic [DTW-1:0]       max_dt,
  output logic [DTW-1:0]       td [N_CH]
);
  ofs_sign_e            sgn;
  logic signed [OW-1:0] mag;

  always_comb begin
    if (ofs > 0)      sgn = OFS_POS;
    else if (ofs < 0) sgn = OFS_NEG;
    else              sgn = OFS_ZERO;
    mag = (ofs < 0) ? -ofs : ofs;
  end

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    localparam ofs_sign_e OWN_SGN = (ch == CH_RAISE) ? OFS_NEG : OFS_POS;
    logic [OW-1:0] sum;
    always_comb begin
      sum = {2'b00, min_dt} + ((sgn == OWN_SGN) ? OW'(mag) : '0);
      if (sum > {2'b00, max_dt}) td[ch] = max_dt;
      else                       td[ch] = sum[DTW-1:0];
    end
  end
endmodule

// File: rtl/npb_deadtime_ctrl.sv
module npb_deadtime_ctrl
  import npb_pkg::*;
#(
  parameter int W    = 12,
  parameter int DTW  = 10,
  parameter int GW   = 8,
  parameter int FRAC = 4,
  localparam int OW  = DTW + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic           sample_stb,
  input  logic           mode_pi,
  input  logic [W-1:0]   v_upper,
  input  logic [W-1:0]   v_lower,
  input  logic [W-1:0]   hyst,
  input  logic [DTW-1:0] step,
  input  logic [GW-1:0]  kp,
  input  logic [GW-1:0]  ki,
  input  logic [DTW-1:0] min_dt,
  input  logic [DTW-1:0] max_dt,
  output logic [DTW-1:0] td_raise,
  output logic [DTW-1:0] td_lower
);
  logic signed [W:0]    ce;
  logic signed [OW-1:0] ofs_bang;
  logic signed [OW-1:0] ofs_pi;
  logic signed [OW-1:0] ofs_sel;
  logic signed [OW-1:0] span;
  logic [DTW-1:0]       td_nxt [N_CH];
  logic                 upd;
  logic                 clr;

  assign upd  = en & sample_stb;
  assign clr  = ~en;
  assign span = $signed({2'b00, max_dt}) - $signed({2'b00, min_dt});

  npb_err #(.W(W)) u_err (
    .v_upper (v_upper),
    .v_lower (v_lower),
    .ce      (ce)
  );

  npb_bang #(.W(W), .DTW(DTW)) u_bang (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .upd     (upd),
    .ce      (ce),
    .hyst    (hyst),
    .step    (step),
    .ofs_nxt (ofs_bang)
  );

  npb_pi #(.W(W), .GW(GW), .DTW(DTW), .FRAC(FRAC)) u_pi (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .upd     (upd),
    .ce      (ce),
    .kp      (kp),
    .ki      (ki),
    .span    (span),
    .ofs_nxt (ofs_pi)
  );

  assign ofs_sel = mode_pi ? ofs_pi : ofs_bang;

  npb_limit #(.DTW(DTW)) u_limit (
    .ofs    (ofs_sel),
    .min_dt (min_dt),
    .max_dt (max_dt),
    .td     (td_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      td_raise <= '0;
      td_lower <= '0;
    end else if (!en) begin
      td_raise <= min_dt;
      td_lower <= min_dt;
    end else if (sample_stb) begin
      td_raise <= td_nxt[CH_RAISE];
      td_lower <= td_nxt[CH_LOWER];
    end
  end
endmodule

// File: rtl/npb_chk.sv
module npb_chk #(
  parameter int W   = 12,
  parameter int DTW = 10
) (
  input logic           clk,
  input logic           rst,
  input logic           en,
  input logic           sample_stb,
  input logic           mode_pi,
  input logic [W-1:0]   v_upper,
  input logic [W-1:0]   v_lower,
  input logic [W-1:0]   hyst,
  input logic [DTW-1:0] min_dt,
  input logic [DTW-1:0] max_dt,
  input logic [DTW-1:0] td_raise,
  input logic [DTW-1:0] td_lower
);
  // R1
  disabled_min_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (td_raise == $past(min_dt) && td_lower == $past(min_dt)));

  // R2
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    (en && !sample_stb) |=> ($stable(td_raise) && $stable(td_lower)));

  // R9
  ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    (en && sample_stb && max_dt >= min_dt) |=>
      (td_raise <= $past(max_dt) && td_lower <= $past(max_dt)));

  // R8
  one_channel_chk: assert property (@(posedge clk) disable iff (rst)
    (en && sample_stb) |=>
      !(td_raise > $past(min_dt) && td_lower > $past(min_dt)));

  // R4
  bang_side_chk: assert property (@(posedge clk) disable iff (rst)
    (en && sample_stb && !mode_pi &&
     ({2'b00, v_lower} > ({2'b00, v_upper} + {2'b00, hyst}))) |=>
      td_raise == $past(min_dt));
endmodule

bind npb_deadtime_ctrl npb_chk #(.W(W), .DTW(DTW)) u_npb_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .sample_stb (sample_stb),
  .mode_pi    (mode_pi),
  .v_upper    (v_upper),
  .v_lower    (v_lower),
  .hyst       (hyst),
  .min_dt     (min_dt),
  .max_dt     (max_dt),
  .td_raise   (td_raise),
  .td_lower   (td_lower)
);

// File: tb/test_npb_deadtime_ctrl.sv
`timescale 1ns/1ps
module test_npb_deadtime_ctrl;
  localparam int W = 12, DTW = 10, GW = 8, FRAC = 4;

  logic clk = 0, rst = 1, en = 0, stb = 0, mode_pi = 0;
  logic [W-1:0] vu = 0, vl = 0, hyst = 0;
  logic [DTW-1:0] step = 0, min_dt = 0, max_dt = 0, td_raise, td_lower;
  logic [GW-1:0] kp = 0, ki = 0;

  int checks = 0, failures = 0;
  bit done = 0;
  longint m_acc = 0, m_bang = 0, e_raise = 0, e_lower = 0;

  always #5 clk = ~clk;

  npb_deadtime_ctrl #(.W(W), .DTW(DTW), .GW(GW), .FRAC(FRAC)) i_npb_deadtime_ctrl (
    .clk(clk), .rst(rst), .en(en), .sample_stb(stb), .mode_pi(mode_pi),
    .v_upper(vu), .v_lower(vl), .hyst(hyst), .step(step), .kp(kp), .ki(ki),
    .min_dt(min_dt), .max_dt(max_dt), .td_raise(td_raise), .td_lower(td_lower)
  );

  function automatic longint clampl(longint x, longint lo, longint hi);
    return (x > hi) ? hi : ((x < lo) ? lo : x);
  endfunction

  // Model of next state, from the requirements
  task automatic model_step();
    longint ce, bn, span, lim, a, up, u;
    if (rst) begin // R10
      m_acc = 0; m_bang = 0; e_raise = 0; e_lower = 0;
    end else if (!en) begin // R1
      m_acc = 0; m_bang = 0; e_raise = min_dt; e_lower = min_dt;
    end else if (stb) begin
      ce = longint'(vl) - longint'(vu); // R3
      if (ce > longint'(hyst)) bn = step;          // R4
      else if (ce < -longint'(hyst)) bn = -longint'(step);
      else bn = m_bang;
      span = longint'(max_dt) - longint'(min_dt);   // R5
      lim = span * (1 << FRAC);
      a = clampl(m_acc + longint'(ki) * ce, -lim, lim);
      up = clampl((longint'(kp) * ce + a) >>> FRAC, -span, span);
      m_acc = a; m_bang = bn;                       // R6
      u = mode_pi ? up : bn;
      e_raise = clampl(longint'(min_dt) + ((u < 0) ? -u : 0), 0, max_dt); // R7 R9
      e_lower = clampl(longint'(min_dt) + ((u > 0) ? u : 0), 0, max_dt);  // R8 R9
    end
  endtask

  task automatic cyc(string tag);
    model_step();
    @(posedge clk); #1;
    checks++;
    if (td_raise !== DTW'(e_raise) || td_lower !== DTW'(e_lower)) begin
      failures++;
      $display("FAIL %s raise=%0d/%0d lower=%0d/%0d (actual/expected)",
               tag, td_raise, e_raise, td_lower, e_lower);
    end
    @(negedge clk);
  endtask

  function automatic string rtag();
    if (rst) return "R10";
    if (!en) return "R1";
    if (!stb) return "R2";
    return mode_pi ? "R5" : "R4";
  endfunction

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    // R10: reset state
    cyc("R10"); cyc("R10");
    rst = 0; min_dt = 40; max_dt = 120; step = 15; hyst = 8; kp = 32; ki = 4;
    // R1: disabled -> minimum
    en = 0; vu = 1000; vl = 900; cyc("R1"); cyc("R1");
    en = 1;
    // R4: inside band holds zero
    mode_pi = 0; stb = 1; vu = 2000; vl = 2005; cyc("R4_band_zero");
    // R4 R7: upper high -> raise channel
    vu = 2100; vl = 2000; cyc("R4_R7_neg");
    // R4: back in band holds -step
    vl = 2095; cyc("R4_hold");
    // R2: no strobe, outputs hold
    stb = 0; vl = 3000; cyc("R2_hold"); cyc("R2_hold");
    // R8: lower high -> lower channel
    stb = 1; cyc("R4_R8_pos");
    // R9: step beyond ceiling
    step = 500; cyc("R9_limit");
    // R5 R6: PI with saturated integrator, large error
    mode_pi = 1; ki = 255; kp = 255; vu = 0; vl = 4095; cyc("R5_sat"); cyc("R5_sat");
    vu = 4095; vl = 0; cyc("R5_sat_neg");
    // R8: zero error, zero gains -> both at minimum
    kp = 0; ki = 0; en = 0; cyc("R1_clear"); en = 1; vu = 1500; vl = 1500; cyc("R8_zero");
    // random phase
    for (int i = 0; i < 6000; i++) begin
      rst = ($urandom_range(0, 999) == 0);
      en = ($urandom_range(0, 19) != 0);
      stb = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 49) == 0) mode_pi = ~mode_pi;
      vu = W'($urandom_range(1800, 2300));
      vl = W'($urandom_range(1800, 2300));
      if ($urandom_range(0, 99) == 0) begin
        hyst = W'($urandom_range(0, 40)); step = DTW'($urandom_range(0, 80));
        kp = GW'($urandom_range(0, 255)); ki = GW'($urandom_range(0, 64));
        min_dt = DTW'($urandom_range(10, 100));
        max_dt = min_dt + DTW'($urandom_range(0, 200));
      end
      cyc(rtag());
    end
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule